// File: doc/BRIEF.md
# Direct-Mapped Write-Through Block Cache

This block is a data cache placed between a processor load/store port and a single main-memory port. It holds 2048 lines. Each line carries a valid flag, a 17-bit tag and a block of four 32-bit words, so the default capacity is 32 KB. Every request address is cut into a tag, a line index, a word-in-block select and a byte offset. The lookup outcome is reported in the same cycle as the request.

A load that hits returns its word at once and the requester never stalls. A load that misses holds the requester stalled while the block is fetched one word at a time over the memory port. The complete block, its tag and its valid flag are written into the indexed line, and then the stall drops with the requested word on the read-data output. Every store is sent through to memory, and the requester stays stalled until memory acknowledges the write. A store that hits also updates the single addressed word in the line. A store that misses leaves the cache exactly as it was, because there is no allocation on writes.

The requester holds its request fields steady while the stall is high. A request completes on a clock edge at which it is present and the stall is low.

Top module: `wt_block_cache`

## Requirements
- R1: An asserted reset invalidates every line. The first load after reset misses (hit low, stall high), including a load to an address that was cached before the reset.
- R2: Address bits 31:15 are the tag, bits 14:4 select one of 2048 lines, and bits 3:2 select the word within the block. Two addresses with the same index and different tags map to the same line and evict each other.
- R3: The hit output is high in the cycle a request is presented exactly when the indexed line is valid and its stored tag equals the address tag.
- R4: A load that hits completes in its first cycle with the stall low, and the read-data output carries the word picked by bits 3:2 from the line.
- R5: A load that misses stalls and issues exactly four memory reads. The read addresses are the block base (bits 3:0 zero) plus 0, 4, 8 and 12, in that order. Each read address is held until memory acknowledges it.
- R6: When the stall of a missed load drops, the read-data output carries the word picked by bits 3:2 from the freshly fetched block. A following load to any word of that block hits.
- R7: Every store issues exactly one memory write that carries the store address and data, issues no memory read, and keeps the requester stalled until memory acknowledges the write.
- R8: A store hit replaces only the addressed word of the line. The other three words keep their old values and the line still hits.
- R9: A store miss leaves the indexed line's tag, valid flag and data unchanged. A load to the line that was resident before the store still hits, and a load to the stored address still misses.
- R10: Address bits 1:0 have no effect on lookup, hit or the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| cpu_hit | output | 1 | Lookup outcome for the present request |
| cpu_stall | output | 1 | Requester must hold its request |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle memory acknowledge; carries read data on reads |
| mem_rdata | input | 32 | Memory read data, valid with the acknowledge |

## Verification
Two functions share a single clock edge on a store hit. The write-through acknowledge from memory and the in-line update of the addressed word both take effect on that edge. The bench provokes this by storing to a word of a block that is already resident. It judges the result through the normal ports. It checks that exactly one memory write with the right address and data was seen. It then reloads the stored word and a neighbour, and requires both to hit with no stall: the stored word must return the new value and the neighbour must return its old value. A second pairing happens at the end of a refill, where the last-word acknowledge writes the whole line and the same held request must turn into a hit. That case is judged by the word on the read-data output in the cycle the stall drops.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } ctl_state_e;

endpackage

// File: rtl/wtc_addr_split.sv
module wtc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int BOFF_W = 2,
  parameter int WOFF_W = 2,
  parameter int IDX_W  = 11,
  parameter int TAG_W  = 17
) (
  input  logic [ADDR_W-1:BOFF_W] word_addr,
  output logic [TAG_W-1:0]       tag,
  output logic [IDX_W-1:0]       idx,
  output logic [WOFF_W-1:0]      woff
);

  localparam int IDX_LO = BOFF_W + WOFF_W;
  localparam int TAG_LO = IDX_LO + IDX_W;

  assign woff = word_addr[IDX_LO-1:BOFF_W];
  assign idx  = word_addr[TAG_LO-1:IDX_LO];
  assign tag  = word_addr[TAG_LO+TAG_W-1:TAG_LO];

endmodule

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
  parameter int LINES      = 2048,
  parameter int TAG_W      = 17,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(LINES)-1:0]     idx,
  output logic                         rd_valid,
  output logic [TAG_W-1:0]             rd_tag,
  output logic [LINE_WORDS*WORD_W-1:0] rd_line,
  input  logic                         fill_en,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [LINE_WORDS*WORD_W-1:0] fill_line,
  input  logic                         upd_en,
  input  logic [$clog2(LINE_WORDS)-1:0] upd_off,
  input  logic [WORD_W-1:0]            upd_word
);

  localparam int IDX_W  = $clog2(LINES);
  localparam int WOFF_W = $clog2(LINE_WORDS);

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // valid flags: the only state that needs a reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[idx] <= fill_tag;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_tag   = tag_mem[idx];

  // one storage bank per word position in the block
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank [LINES];
    logic              bank_we;
    logic [WORD_W-1:0] bank_wd;

    assign bank_we = fill_en || (upd_en && (upd_off == WOFF_W'(w)));
    assign bank_wd = fill_en ? fill_line[w*WORD_W +: WORD_W] : upd_word;

    always_ff @(posedge clk) begin
      if (bank_we) begin
        bank[idx] <= bank_wd;
      end
    end

    assign rd_line[w*WORD_W +: WORD_W] = bank[idx];
  end

  logic [IDX_W-1:0] idx_unused_chk;
  assign idx_unused_chk = idx;

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int BOFF_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic                         lookup_hit,
  output logic                         stall,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_ack,
  input  logic [WORD_W-1:0]            mem_rdata,
  output logic                         fill_en,
  output logic [LINE_WORDS*WORD_W-1:0] fill_line,
  output logic                         upd_en
);

  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int BLK_LO = WOFF_W + BOFF_W;
  localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(LINE_WORDS - 1);

  ctl_state_e        state_q, state_d;
  logic [WOFF_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    stall   = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    fill_en = 1'b0;
    upd_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          if (cpu_we) begin
            stall   = 1'b1;
            state_d = ST_STORE;
          end else if (!lookup_hit) begin
            stall   = 1'b1;
            state_d = ST_FILL;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
      end
      ST_FILL: begin
        stall   = 1'b1;
        mem_req = 1'b1;
        if (mem_ack) begin
          if (cnt_q == LAST_WORD) begin
            fill_en = 1'b1;
            state_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      ST_STORE: begin
        stall   = 1'b1;
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          upd_en  = lookup_hit;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  // refill reads walk the block; stores pass the request address through
  always_comb begin
    if (state_q == ST_FILL) begin
      mem_addr = {cpu_addr[ADDR_W-1:BLK_LO], cnt_q, {BOFF_W{1'b0}}};
    end else begin
      mem_addr = cpu_addr;
    end
  end

  // fill buffer: all but the last word; the last is taken straight from memory
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_fill
    if (w == LINE_WORDS - 1) begin : g_last
      assign fill_line[w*WORD_W +: WORD_W] = mem_rdata;
    end else begin : g_buf
      logic [WORD_W-1:0] buf_q;
      logic              buf_en;

      assign buf_en = (state_q == ST_FILL) && mem_ack && (cnt_q == WOFF_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          buf_q <= '0;
        end else if (buf_en) begin
          buf_q <= mem_rdata;
        end
      end

      assign fill_line[w*WORD_W +: WORD_W] = buf_q;
    end
  end

endmodule

// File: rtl/wt_block_cache.sv
module wt_block_cache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int BOFF_W = $clog2(WORD_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;

  // reset: asynchronous assertion, release aligned to the clock
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WOFF_W-1:0] a_woff;

  wtc_addr_split #(
    .ADDR_W (ADDR_W),
    .BOFF_W (BOFF_W),
    .WOFF_W (WOFF_W),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W)
  ) u_split (
    .word_addr (cpu_addr[ADDR_W-1:BOFF_W]),
    .tag       (a_tag),
    .idx       (a_idx),
    .woff      (a_woff)
  );

  logic              line_valid;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic              fill_en;
  logic [LINE_W-1:0] fill_line;
  logic              upd_en;
  logic              lookup_hit;

  wtc_line_store #(
    .LINES      (LINES),
    .TAG_W      (TAG_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .idx       (a_idx),
    .rd_valid  (line_valid),
    .rd_tag    (line_tag),
    .rd_line   (line_data),
    .fill_en   (fill_en),
    .fill_tag  (a_tag),
    .fill_line (fill_line),
    .upd_en    (upd_en),
    .upd_off   (a_woff),
    .upd_word  (cpu_wdata)
  );

  assign lookup_hit = line_valid && (line_tag == a_tag);

  wtc_ctrl #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS),
    .BOFF_W     (BOFF_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .lookup_hit (lookup_hit),
    .stall      (cpu_stall),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fill_en    (fill_en),
    .fill_line  (fill_line),
    .upd_en     (upd_en)
  );

  assign cpu_hit   = cpu_req && lookup_hit;
  assign cpu_rdata = line_data[a_woff*WORD_W +: WORD_W];
  assign mem_wdata = cpu_wdata;

endmodule

// File: rtl/wt_block_cache_chk.sv
module wt_block_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_hit,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              fill_en
);

  assert_cold_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cpu_hit);

  assert_load_hit_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_hit) |-> !cpu_stall);

  assert_mem_only_when_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall);

  assert_mem_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_fill_on_read_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> (mem_ack && mem_req && !mem_we));

  assert_store_after_write_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall) |-> $past(mem_ack && mem_we));

endmodule

bind wt_block_cache wt_block_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_hit   (cpu_hit),
  .cpu_stall (cpu_stall),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .fill_en   (fill_en)
);

// File: tb/tb_wt_block_cache.sv
`timescale 1ns/1ps
module tb_wt_block_cache;

  localparam int LAT      = 40;
  localparam int WATCHDOG = 100000;
  localparam int NV       = 12;

  // {store, address, store data, expected hit on first cycle}
  localparam logic [65:0] VEC [NV] = '{
    {1'b0, 32'h0000_1234, 32'h0000_0000, 1'b0},  // cold miss, word 1
    {1'b0, 32'h0000_1238, 32'h0000_0000, 1'b1},  // same block, word 2
    {1'b0, 32'h0000_123F, 32'h0000_0000, 1'b1},  // word 3, byte offset 3
    {1'b1, 32'h0000_1234, 32'hCAFE_0001, 1'b1},  // store hit
    {1'b0, 32'h0000_1234, 32'h0000_0000, 1'b1},  // stored word reloaded
    {1'b0, 32'h0000_1230, 32'h0000_0000, 1'b1},  // neighbour unchanged
    {1'b1, 32'h0000_9230, 32'hDEAD_0002, 1'b0},  // store miss, same index
    {1'b0, 32'h0000_1238, 32'h0000_0000, 1'b1},  // old line still resident
    {1'b0, 32'h0000_9230, 32'h0000_0000, 1'b0},  // conflict miss
    {1'b0, 32'h0000_1230, 32'h0000_0000, 1'b0},  // evicted line misses
    {1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0},  // top index, top tag
    {1'b0, 32'hFFFF_FFF1, 32'h0000_0000, 1'b1}   // same block, byte offset 1
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_hit;
  logic        cpu_stall;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  wt_block_cache dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_hit   (cpu_hit),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata)
  );

  // ---------------- behavioural main memory ----------------
  logic [31:0] mem_store [logic [29:0]];
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_addr = '0;
  logic        m_we = 1'b0;
  logic [31:0] m_wd = '0;
  int          rd_total = 0;
  int          wr_total = 0;
  logic [31:0] rd_log [4];
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;

  function automatic logic [31:0] init_word(input logic [29:0] w);
    return {w[15:0] ^ 16'h5A5A, w[29:14]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (mem_store.exists(a[31:2])) return mem_store[a[31:2]];
    return init_word(a[31:2]);
  endfunction

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (m_busy) begin
      if (m_cnt == LAT - 1) begin
        mem_ack <= 1'b1;
        m_busy  <= 1'b0;
        if (m_we) begin
          mem_store[m_addr[31:2]] = m_wd;
          last_wr_addr <= m_addr;
          last_wr_data <= m_wd;
          wr_total     <= wr_total + 1;
        end else begin
          mem_rdata          <= mem_word(m_addr);
          rd_log[rd_total % 4] <= m_addr;
          rd_total           <= rd_total + 1;
        end
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end else if (mem_req) begin
      m_busy <= 1'b1;
      m_cnt  <= 0;
      m_addr <= mem_addr;
      m_we   <= mem_we;
      m_wd   <= mem_wdata;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic first_hit, output logic first_stall,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_req   = 1'b1;
    cpu_we    = we;
    cpu_addr  = a;
    cpu_wdata = wd;
    #1;
    first_hit   = cpu_hit;
    first_stall = cpu_stall;
    waits = 0;
    while (cpu_stall && waits < 5000) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
    cpu_we  = 1'b0;
  endtask

  // run one access and judge it against the reference memory
  task automatic run_op(input string tag, input logic we, input logic [31:0] a,
                        input logic [31:0] wd, input logic exp_hit);
    logic        fh, fs;
    logic [31:0] rd;
    int          w;
    int          rd0, wr0;
    logic [31:0] base;
    logic [31:0] exp_rd;
    rd0  = rd_total;
    wr0  = wr_total;
    base = {a[31:4], 4'h0};
    access(we, a, wd, fh, fs, rd, w);
    chk($sformatf("R3/R2 %s hit flag", tag), 32'(fh), 32'(exp_hit));
    if (we) begin
      chk($sformatf("R7 %s stalled until ack", tag), 32'(fs), 32'd1);
      chk($sformatf("R7 %s one memory write", tag), 32'(wr_total - wr0), 32'd1);
      chk($sformatf("R7/R9 %s no memory read", tag), 32'(rd_total - rd0), 32'd0);
      chk($sformatf("R7 %s write address", tag), last_wr_addr, a);
      chk($sformatf("R7 %s write data", tag), last_wr_data, wd);
    end else begin
      exp_rd = mem_word(a);
      if (exp_hit) begin
        chk($sformatf("R4 %s no stall", tag), 32'(w), 32'd0);
        chk($sformatf("R4 %s no memory read", tag), 32'(rd_total - rd0), 32'd0);
        chk($sformatf("R4/R8/R10 %s data", tag), rd, exp_rd);
      end else begin
        chk($sformatf("R5 %s stall raised", tag), 32'(fs), 32'd1);
        chk($sformatf("R5 %s four reads", tag), 32'(rd_total - rd0), 32'd4);
        for (int k = 0; k < 4; k++) begin
          chk($sformatf("R5 %s read %0d address", tag, k), rd_log[(rd0 + k) % 4], base + 32'(4 * k));
        end
        chk($sformatf("R6 %s data at stall drop", tag), rd, exp_rd);
      end
    end
  endtask

  // ---------------- watchdog ----------------
  logic finished = 1'b0;
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state at the ports
    chk("R1 idle stall after reset", 32'(cpu_stall), 32'd0);
    chk("R1 idle memory request after reset", 32'(mem_req), 32'd0);
    chk("R1 idle hit after reset", 32'(cpu_hit), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op($sformatf("vec%0d", i), VEC[i][65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
    end

    // R8 directed: store hit to word 2, the other words keep their values
    run_op("R8 fill", 1'b0, 32'h0000_4560, 32'h0, 1'b0);
    run_op("R8 store", 1'b1, 32'h0000_4568, 32'h1357_9BDF, 1'b1);
    run_op("R8 word0", 1'b0, 32'h0000_4560, 32'h0, 1'b1);
    run_op("R8 word2", 1'b0, 32'h0000_4568, 32'h0, 1'b1);
    run_op("R8 word3", 1'b0, 32'h0000_456C, 32'h0, 1'b1);

    // R10 directed: byte offset alone changes nothing
    run_op("R10 off0", 1'b0, 32'h0000_456C, 32'h0, 1'b1);
    run_op("R10 off2", 1'b0, 32'h0000_456E, 32'h0, 1'b1);

    // R9 directed: store miss to an empty line does not allocate
    run_op("R9 store", 1'b1, 32'h0000_7770, 32'h2468_ACE0, 1'b0);
    run_op("R9 reload", 1'b0, 32'h0000_7770, 32'h0, 1'b0);

    // R1 directed: reset in mid-run invalidates resident lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op("R1 after reset", 1'b0, 32'h0000_4560, 32'h0, 1'b0);
    run_op("R1 refilled", 1'b0, 32'h0000_4564, 32'h0, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule